// File: doc/BRIEF.md
# Conditional Result Checker Dispatch Controller

This block sits between the commit port of an out-of-order core and a slower re-execution checker. Each finished instruction arrives once with its PC, a two-bit ALU opcode, two operands, the result the core computed and a suspect flag from an external predictor. Every instruction enters a small in-order retire window. Unflagged instructions leave without any check. Flagged instructions are sent, oldest first, into a checker pipeline with a set number of lanes and a set latency. The pipeline recomputes the result and compares it with the reported one.

The core is never stalled. There is no ready signal, and an arriving instruction is always taken. When the window is full and a new instruction arrives, an unverified suspect at the head is retired without its check, and any check still in flight for it is cancelled. When a check fails and its instruction reaches the head, the block raises a one-cycle flush. The flush discards that instruction and every younger one, and it reports a restart PC taken from a history of recently retired PCs. Three counters record how many instructions were verified, bypassed as unflagged, and dropped under congestion.

Top module: `cond_check_dispatch`

## Requirements
- R1: After reset, `ret_valid` and `flush` are low, all three counters read zero and the restart history holds zeros.
- R2: An instruction with `in_suspect` low retires without a check, with `ret_kind` = 2'b00, and increments `cnt_skipped`.
- R3: A suspect instruction whose reported result equals the recomputed one retires with `ret_kind` = 2'b01 and increments `cnt_checked`. The opcode encoding is 2'b00 add, 2'b01 subtract (a minus b), 2'b10 bitwise AND and 2'b11 bitwise XOR, all modulo 2^XLEN.
- R4: Instructions retire in the order they arrived, one per `ret_valid` cycle, whether they were checked, skipped or dropped.
- R5: An arriving instruction is always accepted. When the window holds DEPTH entries, an instruction arrives, and the head is a suspect whose check has not completed, the head retires with `ret_kind` = 2'b10, `cnt_dropped` increments, and any check in flight for it is discarded. The window never holds more than DEPTH entries.
- R6: A suspect instruction whose check mismatches does not retire. When it reaches the head, `flush` is high for exactly one cycle, and that instruction and all younger ones in the window are discarded without retiring.
- R7: While `flush` is high, `restart_pc` equals the PC of the instruction retired HIST retirements earlier (HIST = 10 by default), or zero if fewer than HIST retirements have occurred since reset.
- R8: Each counter increments by exactly one for each retirement of its own kind and is otherwise unchanged. A flushed instruction changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A finished instruction is presented |
| in_pc | input | PCW | Its PC |
| in_op | input | 2 | ALU opcode (see R3) |
| in_a | input | XLEN | First operand |
| in_b | input | XLEN | Second operand |
| in_res | input | XLEN | Result reported by the core |
| in_suspect | input | 1 | Predictor marks it as a possible error victim |
| ret_valid | output | 1 | One instruction retires this cycle |
| ret_pc | output | PCW | PC of the retiring instruction |
| ret_kind | output | 2 | 00 skipped, 01 checked, 10 dropped |
| flush | output | 1 | Mismatch detected: flush and restart |
| restart_pc | output | PCW | Restart point, valid with flush |
| cnt_checked | output | CNT_W | Verified instructions |
| cnt_skipped | output | CNT_W | Unflagged instructions bypassed |
| cnt_dropped | output | CNT_W | Suspects retired unchecked under congestion |

## Verification
Sparse suspect and non-suspect arrivals spread across all four opcodes separate the verify path from the bypass path and test the recompute for each operation. A back-to-back burst of unflagged instructions shows that bypassing never needs the checker. A back-to-back burst of suspects fills the window faster than the checker drains it, which forces drops and tests ordering and counter balance under pressure. Two faulty suspects, one placed after a long retire history and one placed right after reset, test the flush, the discard of younger work and both cases of the restart point.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_AND = 2'b10,
    OP_XOR = 2'b11
  } alu_op_e;

  typedef enum logic [1:0] {
    RK_SKIP    = 2'b00,
    RK_CHECKED = 2'b01,
    RK_DROPPED = 2'b10
  } ret_kind_e;
endpackage

// File: rtl/ccd_alu_check.sv
module ccd_alu_check #(
  parameter int XLEN = 32
) (
  input  logic [1:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [XLEN-1:0] res,
  output logic            match
);
  import ccd_pkg::*;

  logic [XLEN-1:0] recomputed;

  always_comb begin
    case (alu_op_e'(op))
      OP_ADD:  recomputed = a + b;
      OP_SUB:  recomputed = a - b;
      OP_AND:  recomputed = a & b;
      default: recomputed = a ^ b;
    endcase
    match = (recomputed == res);
  end
endmodule

// File: rtl/ccd_check_pipe.sv
module ccd_check_pipe #(
  parameter int BW  = 1,
  parameter int LAT = 3,
  parameter int IW  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic [BW-1:0]          iss_v,
  input  logic [BW-1:0][IW-1:0]  iss_idx,
  input  logic [BW-1:0]          iss_ok,
  input  logic                   kill_v,
  input  logic [IW-1:0]          kill_idx,
  output logic [BW-1:0]          out_v,
  output logic [BW-1:0][IW-1:0]  out_idx,
  output logic [BW-1:0]          out_ok
);
  logic [LAT-1:0][BW-1:0]         st_v, st_v_n;
  logic [LAT-1:0][BW-1:0]         st_ok, st_ok_n;
  logic [LAT-1:0][BW-1:0][IW-1:0] st_idx, st_idx_n;

  always_comb begin
    st_v_n   = st_v;
    st_ok_n  = st_ok;
    st_idx_n = st_idx;
    st_v_n[0]   = iss_v;
    st_ok_n[0]  = iss_ok;
    st_idx_n[0] = iss_idx;
    for (int s = 1; s < LAT; s++) begin
      for (int k = 0; k < BW; k++) begin
        st_v_n[s][k]   = st_v[s-1][k] && !(kill_v && st_idx[s-1][k] == kill_idx);
        st_ok_n[s][k]  = st_ok[s-1][k];
        st_idx_n[s][k] = st_idx[s-1][k];
      end
    end
    if (flush) st_v_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_v   <= '0;
      st_ok  <= '0;
      st_idx <= '0;
    end else begin
      st_v   <= st_v_n;
      st_ok  <= st_ok_n;
      st_idx <= st_idx_n;
    end
  end

  always_comb begin
    for (int k = 0; k < BW; k++) begin
      out_v[k]   = st_v[LAT-1][k] && !(kill_v && st_idx[LAT-1][k] == kill_idx);
      out_idx[k] = st_idx[LAT-1][k];
      out_ok[k]  = st_ok[LAT-1][k];
    end
  end
endmodule

// File: rtl/ccd_pc_hist.sv
module ccd_pc_hist #(
  parameter int HIST = 10,
  parameter int PCW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [PCW-1:0] pc,
  output logic [PCW-1:0] oldest
);
  logic [HIST-1:0][PCW-1:0] ring;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring <= '0;
    end else if (push) begin
      ring[0] <= pc;
      for (int i = 1; i < HIST; i++) ring[i] <= ring[i-1];
    end
  end

  assign oldest = ring[HIST-1];
endmodule

// File: rtl/cond_check_dispatch.sv
module cond_check_dispatch #(
  parameter int XLEN  = 32,
  parameter int PCW   = 32,
  parameter int DEPTH = 4,   // power of two
  parameter int BW    = 1,   // checker lanes, 1 or 2
  parameter int LAT   = 3,   // checker stages, at least 1
  parameter int HIST  = 10,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PCW-1:0]   in_pc,
  input  logic [1:0]       in_op,
  input  logic [XLEN-1:0]  in_a,
  input  logic [XLEN-1:0]  in_b,
  input  logic [XLEN-1:0]  in_res,
  input  logic             in_suspect,
  output logic             ret_valid,
  output logic [PCW-1:0]   ret_pc,
  output logic [1:0]       ret_kind,
  output logic             flush,
  output logic [PCW-1:0]   restart_pc,
  output logic [CNT_W-1:0] cnt_checked,
  output logic [CNT_W-1:0] cnt_skipped,
  output logic [CNT_W-1:0] cnt_dropped
);
  import ccd_pkg::*;

  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_QW = $clog2(DEPTH + 1);

  // retire window storage
  logic [PCW-1:0]  q_pc  [DEPTH];
  logic [1:0]      q_op  [DEPTH];
  logic [XLEN-1:0] q_a   [DEPTH];
  logic [XLEN-1:0] q_b   [DEPTH];
  logic [XLEN-1:0] q_res [DEPTH];
  logic [DEPTH-1:0] q_susp, q_done, q_fail, q_iss;

  logic [PTR_W-1:0]  head, tail, head_n, tail_n;
  logic [CNT_QW-1:0] count, count_n, iss_off, iss_off_n;

  logic hv, full, do_skip, do_chk, do_drop, do_flush, do_ret, acc;

  logic [BW-1:0]             lane_v, lane_ok;
  logic [BW-1:0][PTR_W-1:0]  lane_slot;
  logic [1:0]                lane_op  [BW];
  logic [XLEN-1:0]           lane_a   [BW];
  logic [XLEN-1:0]           lane_b   [BW];
  logic [XLEN-1:0]           lane_res [BW];

  logic [BW-1:0]             wb_v, wb_ok;
  logic [BW-1:0][PTR_W-1:0]  wb_idx;
  logic [PCW-1:0]            hist_oldest;

  // head decision
  always_comb begin
    hv       = (count != '0);
    full     = (count == CNT_QW'(DEPTH));
    do_skip  = hv && !q_susp[head];
    do_chk   = hv && q_susp[head] && q_done[head] && !q_fail[head];
    do_flush = hv && q_susp[head] && q_done[head] && q_fail[head];
    do_drop  = hv && q_susp[head] && !q_done[head] && full && in_valid;
    do_ret   = do_skip || do_chk || do_drop;
    acc      = in_valid && !do_flush;
  end

  // issue selection: oldest entries not yet scanned, never the retiring head
  always_comb begin
    int start_i, adv_i, pos;
    start_i = (do_ret && iss_off == '0) ? 1 : int'(iss_off);
    adv_i   = 0;
    for (int k = 0; k < BW; k++) begin
      pos          = start_i + k;
      lane_slot[k] = head + PTR_W'(pos);
      lane_v[k]    = (pos < int'(count)) && q_susp[lane_slot[k]];
      lane_op[k]   = q_op[lane_slot[k]];
      lane_a[k]    = q_a[lane_slot[k]];
      lane_b[k]    = q_b[lane_slot[k]];
      lane_res[k]  = q_res[lane_slot[k]];
      if (pos < int'(count)) adv_i++;
    end
    iss_off_n = CNT_QW'(start_i + adv_i - (do_ret ? 1 : 0));
    count_n   = count + CNT_QW'(acc) - CNT_QW'(do_ret);
    head_n    = head + PTR_W'(do_ret);
    tail_n    = tail + PTR_W'(acc);
    if (do_flush) begin
      count_n   = '0;
      iss_off_n = '0;
      head_n    = tail;
      tail_n    = tail;
    end
  end

  for (genvar g = 0; g < BW; g++) begin : g_lane
    ccd_alu_check #(.XLEN(XLEN)) i_alu (
      .op(lane_op[g]), .a(lane_a[g]), .b(lane_b[g]), .res(lane_res[g]),
      .match(lane_ok[g])
    );
  end

  ccd_check_pipe #(.BW(BW), .LAT(LAT), .IW(PTR_W)) i_pipe (
    .clk(clk), .rst_n(rst_n), .flush(do_flush),
    .iss_v(lane_v), .iss_idx(lane_slot), .iss_ok(lane_ok),
    .kill_v(do_drop), .kill_idx(head),
    .out_v(wb_v), .out_idx(wb_idx), .out_ok(wb_ok)
  );

  ccd_pc_hist #(.HIST(HIST), .PCW(PCW)) i_hist (
    .clk(clk), .rst_n(rst_n), .push(do_ret), .pc(q_pc[head]),
    .oldest(hist_oldest)
  );

  // window payload: written only on accept, no reset needed
  always_ff @(posedge clk) begin
    if (acc) begin
      q_pc[tail]  <= in_pc;
      q_op[tail]  <= in_op;
      q_a[tail]   <= in_a;
      q_b[tail]   <= in_b;
      q_res[tail] <= in_res;
    end
  end

  // window control and status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head    <= '0;
      tail    <= '0;
      count   <= '0;
      iss_off <= '0;
      q_susp  <= '0;
      q_done  <= '0;
      q_fail  <= '0;
      q_iss   <= '0;
    end else begin
      head    <= head_n;
      tail    <= tail_n;
      count   <= count_n;
      iss_off <= iss_off_n;
      for (int k = 0; k < BW; k++) begin
        if (lane_v[k]) q_iss[lane_slot[k]] <= 1'b1;
        if (wb_v[k]) begin
          q_done[wb_idx[k]] <= 1'b1;
          q_fail[wb_idx[k]] <= !wb_ok[k];
        end
      end
      if (acc) begin
        q_susp[tail] <= in_suspect;
        q_done[tail] <= 1'b0;
        q_fail[tail] <= 1'b0;
        q_iss[tail]  <= 1'b0;
      end
    end
  end

  // retire port, flush and counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_valid   <= 1'b0;
      ret_pc      <= '0;
      ret_kind    <= RK_SKIP;
      flush       <= 1'b0;
      restart_pc  <= '0;
      cnt_checked <= '0;
      cnt_skipped <= '0;
      cnt_dropped <= '0;
    end else begin
      ret_valid <= do_ret;
      flush     <= do_flush;
      if (do_ret) begin
        ret_pc   <= q_pc[head];
        ret_kind <= do_chk ? RK_CHECKED : (do_drop ? RK_DROPPED : RK_SKIP);
      end
      if (do_flush) restart_pc  <= hist_oldest;
      if (do_chk)   cnt_checked <= cnt_checked + 1'b1;
      if (do_skip)  cnt_skipped <= cnt_skipped + 1'b1;
      if (do_drop)  cnt_dropped <= cnt_dropped + 1'b1;
    end
  end

  // ---------------- assertions ----------------
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_QW'(DEPTH));

  a_r6_flush_no_retire: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !ret_valid);

  a_r6_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);

  a_r8_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ret_valid && ret_kind == RK_DROPPED) |->
      (cnt_dropped - $past(cnt_dropped)) == CNT_W'(1));

  a_r8_checked_step: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !(ret_valid && ret_kind == RK_CHECKED)) |-> $stable(cnt_checked));

  for (genvar g = 0; g < BW; g++) begin : g_wb_chk
    a_r5_wb_issued: assert property (@(posedge clk) disable iff (!rst_n)
      wb_v[g] |-> q_iss[wb_idx[g]]);
  end
endmodule

// File: tb/test_cond_check_dispatch.sv
`timescale 1ns/1ps
module test_cond_check_dispatch;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_pc;
  logic [1:0]  in_op;
  logic [31:0] in_a, in_b, in_res;
  logic        in_suspect;
  logic        ret_valid;
  logic [31:0] ret_pc;
  logic [1:0]  ret_kind;
  logic        flush;
  logic [31:0] restart_pc;
  logic [15:0] cnt_checked, cnt_skipped, cnt_dropped;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  cond_check_dispatch i_cond_check_dispatch (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_res(in_res),
    .in_suspect(in_suspect), .ret_valid(ret_valid), .ret_pc(ret_pc),
    .ret_kind(ret_kind), .flush(flush), .restart_pc(restart_pc),
    .cnt_checked(cnt_checked), .cnt_skipped(cnt_skipped),
    .cnt_dropped(cnt_dropped)
  );

  // retirement monitor
  logic [31:0] mon_pc   [512];
  logic [1:0]  mon_kind [512];
  int          nret   = 0;
  int          nflush = 0;
  logic [31:0] last_restart = '0;

  always @(negedge clk) begin
    if (rst_n && ret_valid) begin
      mon_pc[nret]   = ret_pc;
      mon_kind[nret] = ret_kind;
      nret++;
    end
    if (rst_n && flush) begin
      nflush++;
      last_restart = restart_pc;
    end
  end

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_alu(logic [1:0] op, logic [31:0] a, logic [31:0] b);
    case (op)
      2'b00:   return a + b;
      2'b01:   return a - b;
      2'b10:   return a & b;
      default: return a ^ b;
    endcase
  endfunction

  task automatic push(logic [31:0] pc, logic [1:0] op, logic [31:0] a,
                      logic [31:0] b, logic susp, logic corrupt);
    @(negedge clk);
    in_valid   = 1'b1;
    in_pc      = pc;
    in_op      = op;
    in_a       = a;
    in_b       = b;
    in_res     = ref_alu(op, a, b) ^ (corrupt ? 32'h1 : 32'h0);
    in_suspect = susp;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
  endtask

  // R1
  task automatic t_reset();
    do_reset();
    check("R1 ret_valid", ret_valid, 0);
    check("R1 flush", flush, 0);
    check("R1 cnt_checked", cnt_checked, 0);
    check("R1 cnt_skipped", cnt_skipped, 0);
    check("R1 cnt_dropped", cnt_dropped, 0);
  endtask

  // R2, R3, R4: sparse mix over all opcodes
  task automatic t_sparse();
    int base = nret;
    logic [15:0] c0 = cnt_checked, s0 = cnt_skipped, d0 = cnt_dropped;
    logic        susp [6] = '{1, 0, 1, 1, 1, 0};
    logic [1:0]  ops  [6] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b01, 2'b00};
    for (int i = 0; i < 6; i++) begin
      push(32'h100 + 4*i, ops[i], 32'h1234_5678 + i, 32'h0F0F_00FF * (i+1), susp[i], 0);
      idle(10);
    end
    check("R4 sparse retire count", nret - base, 6);
    for (int i = 0; i < 6; i++) begin
      check("R4 sparse order", mon_pc[base+i], 32'h100 + 4*i);
      check(susp[i] ? "R3 checked kind" : "R2 skip kind", mon_kind[base+i],
            susp[i] ? 2'b01 : 2'b00);
    end
    check("R8 sparse checked", cnt_checked - c0, 4);
    check("R2 sparse skipped", cnt_skipped - s0, 2);
    check("R8 sparse dropped", cnt_dropped - d0, 0);
  endtask

  // R2: unflagged burst never waits on the checker
  task automatic t_skip_burst();
    int base = nret;
    logic [15:0] s0 = cnt_skipped;
    for (int i = 0; i < 8; i++) push(32'h200 + 4*i, 2'b11, i, 7, 0, 0);
    idle(10);
    check("R2 burst retire count", nret - base, 8);
    for (int i = 0; i < 8; i++) begin
      check("R4 burst order", mon_pc[base+i], 32'h200 + 4*i);
      check("R2 burst kind", mon_kind[base+i], 2'b00);
    end
    check("R2 burst skipped", cnt_skipped - s0, 8);
  endtask

  // R5: suspect burst overruns the checker
  task automatic t_congest();
    int base = nret;
    int nck = 0, ndr = 0;
    logic [15:0] c0 = cnt_checked, d0 = cnt_dropped;
    for (int i = 0; i < 16; i++) push(32'h300 + 4*i, 2'(i), 32'hA000 + i, 32'h55 + i, 1, 0);
    idle(20);
    check("R5 congest retire count", nret - base, 16);
    for (int i = 0; i < 16; i++) begin
      check("R4 congest order", mon_pc[base+i], 32'h300 + 4*i);
      if (mon_kind[base+i] == 2'b01) nck++;
      else if (mon_kind[base+i] == 2'b10) ndr++;
    end
    check("R5 kinds are checked or dropped", nck + ndr, 16);
    check("R5 drops occurred", ndr > 0, 1);
    check("R8 congest dropped", cnt_dropped - d0, ndr);
    check("R8 congest checked", cnt_checked - c0, nck);
    check("R6 no flush on good data", nflush, 0);
  endtask

  // R6, R7: mismatch after long history
  task automatic t_fault();
    int base = nret;
    logic [15:0] c0 = cnt_checked, s0 = cnt_skipped, d0 = cnt_dropped;
    int f0 = nflush;
    for (int i = 0; i < 12; i++) push(32'h400 + 4*i, 2'b00, i, i, 0, 0);
    idle(5);
    push(32'h500, 2'b00, 32'h10, 32'h20, 1, 1);
    push(32'h504, 2'b01, 32'h10, 32'h20, 0, 0);
    idle(15);
    check("R6 one flush pulse", nflush - f0, 1);
    check("R7 restart pc", last_restart, 32'h408);
    check("R6 faulty and younger not retired", nret - base, 12);
    check("R8 flush skipped", cnt_skipped - s0, 12);
    check("R8 flush checked", cnt_checked - c0, 0);
    check("R8 flush dropped", cnt_dropped - d0, 0);
    push(32'h408, 2'b00, 1, 2, 0, 0);
    idle(5);
    check("R4 resume after flush", mon_pc[nret-1], 32'h408);
  endtask

  // R7: short history gives zero
  task automatic t_fault_early();
    int f0;
    do_reset();
    check("R1 counters after second reset", cnt_skipped, 0);
    f0 = nflush;
    push(32'h600, 2'b10, 3, 5, 0, 0);
    push(32'h604, 2'b10, 3, 5, 0, 0);
    push(32'h608, 2'b11, 9, 9, 1, 1);
    idle(15);
    check("R6 early flush pulse", nflush - f0, 1);
    check("R7 restart zero with short history", last_restart, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_pc = '0; in_op = '0; in_a = '0; in_b = '0; in_res = '0; in_suspect = 1'b0;
    t_reset();
    t_sparse();
    t_skip_burst();
    t_congest();
    t_fault();
    t_fault_early();
    summary();
    $finish;
  end
endmodule